// File: doc/BRIEF.md
# Resistive Cell Random-Bit Pulse Sequencer

This block sequences one bipolar resistive-switching cell through a pulse schedule that harvests two random bits per operation cycle. The first bit comes from a positive probe pulse near the median set threshold. The second bit comes from a negative probe pulse near the median reset threshold. A read pulse follows each probe. A strong recovery pulse is added only when a read shows that the cell is not in the state the next step needs.

The block never produces voltages. It asks an external pulse driver for one pulse at a time: it places a 3-bit pulse code on `pulse_type`, raises `pulse_req`, and waits for a one-clock `pulse_done`. A comparator bit, `cell_lrs`, reports the cell's resistance after a read pulse. The harvested pair appears on `rnd_word` for one clock with `rnd_valid`. The `run` input starts operation and stops it at a cycle boundary. A per-cycle pulse budget raises `err` and halts the sequencer if a cycle would run past its allowance.

Top module: `rng_pulse_seq`

## Requirements
- R1: After reset `pulse_req`, `rnd_valid` and `err` are 0 and `pulse_type` is 0 (idle), and they stay so while `run` is low.
- R2: Pulse codes are 0 idle, 1 positive probe, 2 negative probe, 3 full set, 4 full reset, 5 read. Once raised, `pulse_req` stays high with an unchanged code until the clock in which `pulse_done` is 1.
- R3: The first time `run` is seen high after reset, a single full-reset pulse (code 4) is issued before any probe. Later starts do not repeat it.
- R4: Every cycle begins with a positive probe (1) and then a read (5). The read maps `cell_lrs`=1 (low resistance) to first bit 1 and `cell_lrs`=0 to first bit 0.
- R5: If the first bit is 0, a full-set pulse (3) is issued and then the negative probe (2). If the first bit is 1, the negative probe follows the read directly.
- R6: A read (5) follows the negative probe and gives the second bit (1 = low resistance). If the second bit is 1, a full-reset pulse (4) ends the cycle. If it is 0, the next cycle's positive probe follows at once.
- R7: `rnd_valid` is high for exactly one clock, with `rnd_word` = {first bit, second bit}. It rises in the clock after the done of the second read when the second bit is 0, or after the done of the full reset when the second bit is 1.
- R8: `cell_lrs` is used only in a clock in which `pulse_done` is 1 for a read pulse. Its value at any other time has no effect on the bits.
- R9: When `run` is low at the end of a cycle, the sequencer goes idle and issues no further pulses. A cycle in progress always completes.
- R10: If a cycle would need more than PULSE_LIMIT pulses, `err` goes high, `pulse_req` drops, and the sequencer stays halted until reset. No word is delivered for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable; when low, the sequencer stops at the next cycle boundary |
| pulse_done | input | 1 | One-clock completion from the pulse driver |
| cell_lrs | input | 1 | Comparator result: 1 means low resistance |
| pulse_req | output | 1 | Pulse request, held until done |
| pulse_type | output | 3 | Requested pulse code |
| rnd_word | output | 2 | Harvested bits {first, second} |
| rnd_valid | output | 1 | One-clock strobe for `rnd_word` |
| err | output | 1 | Sticky pulse-budget violation flag |

## Verification
Assertions check on every cycle that a request is held with a stable code until done, that codes are legal, that the valid strobe lasts one clock, that the step after each probe and full set follows the order, and that an error leaves the request low. The bench scenarios are needed for the data-dependent branches. These are the recovery pulses inserted or skipped for each of the four bit pairs, the bit values carried into the word, the single power-up reset, a stop honoured only at a cycle boundary, and the budget trip on a reduced limit. A driver that toggles the comparator outside read-done clocks shows that the bits do not depend on it.

// File: rtl/rng_pulse_seq.sv
module rng_pulse_seq #(
  parameter int PULSE_LIMIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pulse_done,
  input  logic       cell_lrs,
  output logic       pulse_req,
  output logic [2:0] pulse_type,
  output logic [1:0] rnd_word,
  output logic       rnd_valid,
  output logic       err
);
  localparam int CW = $clog2(PULSE_LIMIT + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_PPROBE, S_READ1, S_FSET, S_NPROBE, S_READ2, S_FRESET
  } st_t;

  st_t           state, nxt;
  logic [CW-1:0] cnt;
  logic          primed, bit1;
  logic          in_cycle, cycle_end, over;

  assign pulse_req = (state != S_IDLE);
  assign in_cycle  = (state != S_IDLE) && (state != S_INIT);
  assign cycle_end = pulse_done && ((state == S_READ2 && !cell_lrs) || state == S_FRESET);
  assign over      = pulse_done && in_cycle && !cycle_end && ((cnt + 1'b1) >= CW'(PULSE_LIMIT));

  always_comb begin
    case (state)
      S_PPROBE: pulse_type = 3'd1;
      S_NPROBE: pulse_type = 3'd2;
      S_FSET:   pulse_type = 3'd3;
      S_INIT,
      S_FRESET: pulse_type = 3'd4;
      S_READ1,
      S_READ2:  pulse_type = 3'd5;
      default:  pulse_type = 3'd0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (run && !err) nxt = primed ? S_PPROBE : S_INIT;
      S_INIT:   if (pulse_done) nxt = run ? S_PPROBE : S_IDLE;
      S_PPROBE: if (pulse_done) nxt = S_READ1;
      S_READ1:  if (pulse_done) nxt = cell_lrs ? S_NPROBE : S_FSET;
      S_FSET:   if (pulse_done) nxt = S_NPROBE;
      S_NPROBE: if (pulse_done) nxt = S_READ2;
      S_READ2:  if (pulse_done) nxt = cell_lrs ? S_FRESET : (run ? S_PPROBE : S_IDLE);
      S_FRESET: if (pulse_done) nxt = run ? S_PPROBE : S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      primed    <= 1'b0;
      bit1      <= 1'b0;
      err       <= 1'b0;
      rnd_valid <= 1'b0;
      rnd_word  <= 2'b00;
    end else begin
      rnd_valid <= 1'b0;
      if (over) begin
        err   <= 1'b1;
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        state <= nxt;
        if (cycle_end || !in_cycle) cnt <= '0;
        else if (pulse_done)        cnt <= cnt + 1'b1;
        if (state == S_INIT && pulse_done) primed <= 1'b1;
        if (state == S_READ1 && pulse_done) bit1 <= cell_lrs;
        if (cycle_end) begin
          rnd_valid <= 1'b1;
          rnd_word  <= {bit1, state == S_FRESET};
        end
      end
    end
  end

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req && !pulse_done && !err) |=> (pulse_req && $stable(pulse_type)));
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req == (pulse_type inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}));
  a_r4_probe_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && pulse_type == 3'd1) |=> (pulse_type == 3'd5 || err));
  a_r5_set_then_nprobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && pulse_type == 3'd3) |=> (pulse_type == 3'd2 || err));
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |=> !rnd_valid);
  a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !pulse_req && !rnd_valid));
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PULSE_LIMIT));
endmodule

// File: tb/rng_pulse_seq_tb.sv
module rng_pulse_seq_tb;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, pulse_done = 1'b0, cell_lrs = 1'b0;
  logic pulse_req, rnd_valid, err;
  logic [2:0] pulse_type;
  logic [1:0] rnd_word;

  logic done2 = 1'b0;
  logic req2, valid2, err2;
  logic [2:0] type2;
  logic [1:0] word2;

  int n_chk = 0, n_fail = 0, n_valid = 0, valid2_seen = 0;
  logic [2:0] exp_type[$];
  string      exp_tag[$];
  logic       rd_q[$];
  logic [1:0] exp_word[$];

  always #2.5 clk = ~clk;

  rng_pulse_seq u_dut (.clk(clk), .rst_n(rst_n), .run(run), .pulse_done(pulse_done),
    .cell_lrs(cell_lrs), .pulse_req(pulse_req), .pulse_type(pulse_type),
    .rnd_word(rnd_word), .rnd_valid(rnd_valid), .err(err));

  rng_pulse_seq #(.PULSE_LIMIT(4)) u_dut_lim (.clk(clk), .rst_n(rst_n), .run(run),
    .pulse_done(done2), .cell_lrs(1'b1), .pulse_req(req2), .pulse_type(type2),
    .rnd_word(word2), .rnd_valid(valid2), .err(err2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_pulse(input logic [2:0] t, input string tag);
    exp_type.push_back(t);
    exp_tag.push_back(tag);
  endtask

  task automatic plan_cycle(input logic b1, input logic b2);
    push_pulse(3'd1, "R4 probe+");
    push_pulse(3'd5, "R4 read1");
    rd_q.push_back(b1);
    if (!b1) push_pulse(3'd3, "R5 full set");
    push_pulse(3'd2, "R5 probe-");
    push_pulse(3'd5, "R6 read2");
    rd_q.push_back(b2);
    if (b2) push_pulse(3'd4, "R6 full reset");
    exp_word.push_back({b1, b2});
  endtask

  // Driver: answers each request after LAT clocks, toggles the comparator outside read-done clocks
  initial begin
    forever begin
      @(negedge clk);
      pulse_done = 1'b0;
      cell_lrs = ~cell_lrs;
      if (pulse_req && rst_n) begin
        for (int i = 1; i < LAT; i++) begin
          @(negedge clk);
          cell_lrs = ~cell_lrs;
        end
        if (exp_type.size() == 0) begin
          chk(1'b0, "R9 unexpected pulse", pulse_type, 0);
        end else begin
          string tg;
          logic [2:0] et;
          et = exp_type.pop_front();
          tg = exp_tag.pop_front();
          chk(pulse_type == et, tg, pulse_type, et);
        end
        if (pulse_type == 3'd5 && rd_q.size() > 0) cell_lrs = rd_q.pop_front();
        pulse_done = 1'b1;
      end
    end
  end

  // Monitor: scoreboard of harvested words
  initial begin
    forever begin
      @(negedge clk);
      if (rnd_valid) begin
        n_valid++;
        if (exp_word.size() == 0) chk(1'b0, "R7 unexpected word", rnd_word, 0);
        else begin
          logic [1:0] ew;
          ew = exp_word.pop_front();
          chk(rnd_word == ew, "R7 word", rnd_word, ew);
        end
        @(negedge clk);
        chk(!rnd_valid, "R7 strobe width", rnd_valid, 0);
        if (rnd_valid) n_valid++;
      end
    end
  end

  // Responder for the reduced-budget instance
  initial begin
    forever begin
      @(negedge clk);
      done2 = req2 && rst_n && !done2;
      if (valid2) valid2_seen++;
    end
  end

  task automatic wait_valids(input int n);
    int t = 0;
    while (n_valid < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(n_valid >= n, "R7 words delivered", n_valid, n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pulse_req == 1'b0, "R1 req idle", pulse_req, 0);
    chk(pulse_type == 3'd0, "R1 type idle", pulse_type, 0);
    chk(rnd_valid == 1'b0, "R1 valid idle", rnd_valid, 0);
    chk(err == 1'b0, "R1 err idle", err, 0);

    push_pulse(3'd4, "R3 power-up reset");
    plan_cycle(1'b0, 1'b0);
    plan_cycle(1'b0, 1'b1);
    plan_cycle(1'b1, 1'b0);
    plan_cycle(1'b1, 1'b1);
    plan_cycle(1'b1, 1'b1);
    plan_cycle(1'b0, 1'b0);
    plan_cycle(1'b1, 1'b0);
    run = 1'b1;
    wait_valids(6);
    run = 1'b0;
    wait_valids(7);
    repeat (40) @(negedge clk);
    chk(pulse_req == 1'b0, "R9 stopped", pulse_req, 0);
    chk(exp_type.size() == 0, "R9 schedule drained", exp_type.size(), 0);
    chk(err == 1'b0, "R10 no error at default budget", err, 0);

    plan_cycle(1'b0, 1'b1);
    plan_cycle(1'b1, 1'b0);
    run = 1'b1;
    wait_valids(8);
    run = 1'b0;
    wait_valids(9);
    repeat (40) @(negedge clk);
    chk(exp_type.size() == 0, "R3 no second power-up reset", exp_type.size(), 0);
    chk(pulse_req == 1'b0, "R9 stopped again", pulse_req, 0);
    chk(exp_word.size() == 0, "R8 all words matched", exp_word.size(), 0);

    chk(err2 == 1'b1, "R10 budget trip", err2, 1);
    chk(req2 == 1'b0, "R10 request dropped", req2, 0);
    chk(valid2_seen == 0, "R10 no word", valid2_seen, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule